// File: doc/BRIEF.md
# Receive Sample Decimator

This block reduces the rate of a receive sample stream coming from a data converter before the samples are handed to a host interface. Out of every N valid input samples it forwards one and discards the others. N runs from 1 to 8 and is chosen by a 3-bit rate control that a host processor drives.

The rate control is active-low and counts skipped samples. The block inverts the control word to get the number of samples to drop after each forwarded sample (N - 1). A down-counter tracks the drops. Cycles without a valid input sample do not move the counter. A new rate is picked up only when the next sample is forwarded, so a count in progress always finishes at the old rate. A synchronous reset, or dropping the stream enable, clears the counter so that the next valid sample is forwarded. Each forwarded sample appears on a registered data output, with a one-cycle valid pulse.

Top module: `rx_decimator`

## Requirements
- R1: While reset is high and in the cycle after it, out_valid is 0. The first valid input sample after reset is forwarded, whatever the rate control holds.
- R2: With rate_n = 3'b111 (N = 1), every valid input sample with stream_en high is forwarded.
- R3: The number of valid samples dropped after each forwarded sample is the bitwise inverse of rate_n, taken as an unsigned value. For example, 3'b110 keeps one sample in two and 3'b101 keeps one in three.
- R4: With rate_n = 3'b000 (N = 8), exactly one of every eight valid samples is forwarded, and the seven that follow it are dropped.
- R5: A cycle with in_valid low does not advance the drop count and does not produce an output pulse.
- R6: rate_n is sampled only when a sample is forwarded. A change made during a count leaves the remaining drops of that count unchanged.
- R7: While stream_en is low, no sample is forwarded and the count is cleared. The first valid sample after stream_en returns high is forwarded.
- R8: A sample that is forwarded on clock edge t appears on out_data after edge t, and out_valid is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stream_en | input | 1 | Stream enable; low clears the count and blocks output |
| rate_n | input | 3 | Active-low rate control, equal to ~(N-1) |
| in_valid | input | 1 | Input sample valid |
| in_data | input | DATA_W | Input sample |
| out_valid | output | 1 | One-cycle pulse for each forwarded sample |
| out_data | output | DATA_W | Registered forwarded sample |

## Verification
The hardest case to reach from the ports is a rate change that lands in the middle of a long drop count, combined with idle gaps and a stream enable that falls partway through a count. Directed sequences set the rate to 8, forward one sample, change the rate to 1 after two drops and insert idle cycles. They then confirm that the five remaining drops still happen before every sample starts to pass. Beyond that, a long run from a seeded $urandom changes the rate, the valid gaps and the enable at random. Each output is compared against a bench model of the drop count.

// File: rtl/rxdec_pkg.sv
package rxdec_pkg;
    localparam int CTRL_W     = 3;
    localparam int CNT_W      = CTRL_W;
    localparam int DATA_W_DEF = 16;

    typedef logic [CNT_W-1:0] skip_t;

    // Active-low control word holds the number of samples to drop.
    function automatic skip_t ctrl_to_skip(input logic [CTRL_W-1:0] ctrl);
        return skip_t'(~ctrl);
    endfunction
endpackage

// File: rtl/rxdec_rate_decode.sv
module rxdec_rate_decode
    import rxdec_pkg::*;
(
    input  logic [CTRL_W-1:0] rate_n,
    output skip_t             skip_n
);
    always_comb begin
        skip_n = ctrl_to_skip(rate_n);
    end
endmodule

// File: rtl/rxdec_skip_counter.sv
module rxdec_skip_counter
    import rxdec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stream_en,
    input  logic  in_valid,
    input  skip_t skip_n,
    output logic  keep,
    output skip_t cnt_q
);
    logic advance;

    always_comb begin
        advance = stream_en && in_valid;
        keep    = advance && (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || !stream_en) begin
            cnt_q <= '0;
        end else if (advance) begin
            if (cnt_q == '0) begin
                cnt_q <= skip_n;
            end else begin
                cnt_q <= cnt_q - skip_t'(1);
            end
        end
    end
endmodule

// File: rtl/rxdec_out_stage.sv
module rxdec_out_stage #(
    parameter int DATA_W = rxdec_pkg::DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              keep,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= keep;
            if (keep) begin
                out_data <= in_data;
            end
        end
    end
endmodule

// File: rtl/rx_decimator.sv
module rx_decimator
    import rxdec_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stream_en,
    input  logic [CTRL_W-1:0] rate_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    skip_t skip_n;
    skip_t skip_cnt;
    logic  keep_now;

    rxdec_rate_decode u_dec (
        .rate_n (rate_n),
        .skip_n (skip_n)
    );

    rxdec_skip_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .stream_en (stream_en),
        .in_valid  (in_valid),
        .skip_n    (skip_n),
        .keep      (keep_now),
        .cnt_q     (skip_cnt)
    );

    rxdec_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .keep      (keep_now),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/rx_decimator_checker.sv
module rx_decimator_checker
    import rxdec_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              stream_en,
    input logic [CTRL_W-1:0] rate_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input skip_t             cnt,
    input logic              keep
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && cnt == '0));

    assert_zero_count_forwards_R2: assert property (@(posedge clk) disable iff (rst)
        (stream_en && in_valid && cnt == '0) |=> out_valid);

    assert_drop_decrements_R3: assert property (@(posedge clk) disable iff (rst)
        (stream_en && in_valid && cnt != '0) |=> (!out_valid && cnt == $past(cnt) - skip_t'(1)));

    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (stream_en && !in_valid) |=> (!out_valid && $stable(cnt)));

    assert_rate_loaded_on_keep_R6: assert property (@(posedge clk) disable iff (rst)
        keep |=> (cnt == skip_t'(~$past(rate_n))));

    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (rst)
        !stream_en |=> (!out_valid && cnt == '0));

    assert_output_data_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data == $past(in_data)));
endmodule

bind rx_decimator rx_decimator_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stream_en (stream_en),
    .rate_n    (rate_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .cnt       (skip_cnt),
    .keep      (keep_now)
);

// File: tb/rx_decimator_test.sv
`timescale 1ns/1ps
module rx_decimator_test;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stream_en = 1'b0;
    logic [2:0]    rate_n = 3'b111;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int unsigned mcnt = 0;
    int unsigned seed = 32'h5eed_1234;

    always #2 clk = ~clk;

    rx_decimator #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .stream_en(stream_en), .rate_n(rate_n),
        .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int unsigned drops_for(input logic [2:0] r);
        return 32'(3'(~r));
    endfunction

    task automatic check(input string req, input logic got_v, input logic exp_v,
                         input logic [DW-1:0] got_d, input logic [DW-1:0] exp_d);
        checks++;
        if (got_v !== exp_v || (exp_v && got_d !== exp_d)) begin
            errors++;
            $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                     req, got_v, got_d, exp_v, exp_d);
        end
    endtask

    task automatic step(input string req, input logic v, input logic en, input logic [2:0] r);
        logic exp_keep;
        logic [DW-1:0] d;
        d = DW'($urandom(seed));
        seed = seed + 1;
        in_valid = v; stream_en = en; rate_n = r; in_data = d;
        exp_keep = en && v && (mcnt == 0);
        if (!en) mcnt = 0;
        else if (v) mcnt = (mcnt == 0) ? drops_for(r) : mcnt - 1;
        @(posedge clk); #1;
        check(req, out_valid, exp_keep, out_data, d);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: valid=x data=x expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", out_valid, 1'b0, out_data, '0);
        rst = 1'b0; mcnt = 0;
        // R1: first sample after reset kept even at rate 8
        step("R1", 1, 1, 3'b000);
        // R4: seven drops then a keep, twice
        for (int i = 0; i < 15; i++) step("R4", 1, 1, 3'b000);
        // R7: disable mid count, first valid afterwards kept
        step("R7", 1, 1, 3'b000);
        step("R7", 1, 1, 3'b000);
        step("R7", 1, 0, 3'b000);
        step("R7", 1, 0, 3'b000);
        step("R7", 1, 1, 3'b000);
        // R2: rate 1 -- count above must drain first (R6), then all pass
        for (int i = 0; i < 7; i++) step("R6", 1, 1, 3'b111);
        for (int i = 0; i < 8; i++) step("R2", 1, 1, 3'b111);
        // R3: rate 2 and rate 3
        for (int i = 0; i < 8; i++) step("R3", 1, 1, 3'b110);
        for (int i = 0; i < 9; i++) step("R3", 1, 1, 3'b101);
        // R6 and R5: rate 8 keep, two drops, switch to 1 with idle gaps
        rst = 1'b1; @(posedge clk); #1; rst = 1'b0; mcnt = 0;
        step("R6", 1, 1, 3'b000);
        step("R6", 1, 1, 3'b000);
        step("R6", 1, 1, 3'b000);
        step("R5", 0, 1, 3'b111);
        step("R5", 0, 1, 3'b111);
        for (int i = 0; i < 5; i++) step("R6", 1, 1, 3'b111);
        step("R6", 1, 1, 3'b111);
        step("R8", 1, 1, 3'b111);
        step("R8", 0, 1, 3'b111);
        // Random mix
        begin
            logic [2:0] r;
            r = 3'b011;
            for (int i = 0; i < 3000; i++) begin
                if ($urandom(seed + 7) % 40 == 0) r = 3'($urandom(seed + 11));
                step("R3", ($urandom(seed + 3) % 4) != 0, ($urandom(seed + 5) % 50) != 0, r);
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule